// File: doc/BRIEF.md
# Configurable 1:2 / 1:4 Word Demultiplexer

This block takes a stream of 11-bit samples, one per clock, and deals them out across four output ports (A, B, C, D). Each sample carries ten data bits and an out-of-range flag in bit 10. A ratio select chooses between two-port and four-port operation. In two-port operation samples go to A and B. In four-port operation they go to A, B, C and D in turn, always starting with port A after reset. Each group of samples that fills every active port once is called a frame.

An output-mode select decides how the ports update. In simultaneous mode all active ports update together once the frame is complete. In staggered mode each port updates as soon as its own sample arrives. In staggered mode each port also gives up its bit 10 to carry a one-cycle ready strobe for that port. A global data-ready output marks each new frame, either as a one-cycle pulse or as a half-rate toggle whose rising and falling edges both count.

A self-test select replaces the input stream with a fixed alternating checkerboard and forces four-port operation. The block must be reset asynchronously before use. The mode inputs are captured at the first clock after reset is released, and outputs stay quiet until a fixed start-up latency has passed.

Top module: `word_demux`

## Requirements
- R1: With ratio_sel=0 (two-port) and self-test off, input samples go alternately to ports A and B, starting with A after reset. port_c and port_d stay at zero.
- R2: With ratio_sel=1 (four-port), input samples go to ports A, B, C and D in that order, starting with A after reset.
- R3: With stagger_sel=0, all active ports update together at the clock edge that captures the frame's last sample. Each port shows its sample unchanged, with the out-of-range flag in bit 10.
- R4: With stagger_sel=1, a port updates at the edge that captures its own sample. Its bit 10 is a ready strobe that is 1 for exactly the one cycle after that edge. Bits 9..0 carry the data.
- R5: With dr_half_sel=0, data_ready is 1 for the single cycle after each frame-completing edge and 0 otherwise.
- R6: With dr_half_sel=1, data_ready toggles at each frame-completing edge. Its first rise marks the first visible frame.
- R7: With selftest_sel=1, four-port operation is forced and input data is ignored. In phase 0, bits 9..0 of A, B and D are 1010101010 (bit 0 = 0) and port C is 0101010101. Phase 1 is the bitwise complement of phase 0, and the phases alternate frame by frame. Bit 10 is 0 in simultaneous mode.
- R8: rst_n=0 clears every output to zero at once, without waiting for a clock. After release, all outputs stay zero until the 8th rising edge. The first visible frame is the one completed at that edge (samples 5 to 8 in four-port mode, samples 7 and 8 in two-port mode, counting samples from 1 at the first edge).
- R9: The mode inputs (ratio_sel, stagger_sel, dr_half_sel, selftest_sel) are sampled at the first rising edge after reset release. Later changes made without a reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_in | input | 11 | Sample: bits 9..0 data, bit 10 out-of-range flag |
| ratio_sel | input | 1 | 0: two ports (A, B); 1: four ports |
| stagger_sel | input | 1 | 0: simultaneous update; 1: staggered with per-port strobe in bit 10 |
| dr_half_sel | input | 1 | 0: data_ready pulses; 1: data_ready toggles |
| selftest_sel | input | 1 | 1: checkerboard self-test, forces four ports |
| port_a | output | 11 | Port A word |
| port_b | output | 11 | Port B word |
| port_c | output | 11 | Port C word |
| port_d | output | 11 | Port D word |
| data_ready | output | 1 | Global frame marker |

## Verification
The bench builds the block with its default parameters: a 10-bit data field and an 8-clock start-up latency. These values make the full pattern fit in the bench's short runs. The start-up window ends exactly on a frame boundary in both ratios. The latency is short enough that every ratio, output mode, strobe type and self-test phase is reached many times within a few hundred clocks. Random samples, including random out-of-range flags, and random toggling of the mode inputs after capture, test data placement and the rule that mode changes are ignored without a reset.

// File: rtl/word_demux.sv
module word_demux #(
  parameter int DW      = 10,
  parameter int STARTUP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW:0]   sample_in,
  input  logic          ratio_sel,
  input  logic          stagger_sel,
  input  logic          dr_half_sel,
  input  logic          selftest_sel,
  output logic [DW:0]   port_a,
  output logic [DW:0]   port_b,
  output logic [DW:0]   port_c,
  output logic [DW:0]   port_d,
  output logic          data_ready
);
  localparam int BW = $clog2(STARTUP + 1);
  localparam logic [BW-1:0] LIVE_AT = BW'(STARTUP);
  localparam logic [BW-1:0] GATE_AT = BW'(STARTUP - 1);

  logic [BW-1:0] boot;
  logic          cfg_four, cfg_stag, cfg_half, cfg_bist;
  logic [1:0]    slot;
  logic          phase, drq;
  logic [DW:0]   hold [4];
  logic [DW:0]   word [4];
  logic [3:0]    stb;
  logic [DW:0]   vis  [4];

  wire first = (boot == '0);
  wire live  = (boot == LIVE_AT);
  wire gate  = (boot >= GATE_AT);
  wire four  = first ? (ratio_sel | selftest_sel) : cfg_four;
  wire stag  = first ? stagger_sel  : cfg_stag;
  wire half  = first ? dr_half_sel  : cfg_half;
  wire bist  = first ? selftest_sel : cfg_bist;
  wire last  = four ? (slot == 2'd3) : (slot == 2'd1);

  function automatic logic [DW-1:0] pat(input int k, input logic ph);
    logic [DW-1:0] p;
    for (int i = 0; i < DW; i++) p[i] = i[0];
    return (((k == 2) ? 1'b1 : 1'b0) ^ ph) ? ~p : p;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot  <= '0;
      slot  <= '0;
      phase <= 1'b0;
      drq   <= 1'b0;
      stb   <= '0;
      {cfg_four, cfg_stag, cfg_half, cfg_bist} <= '0;
      for (int k = 0; k < 4; k++) begin
        hold[k] <= '0;
        word[k] <= '0;
      end
    end else begin
      if (!live) boot <= boot + 1'b1;
      if (first) {cfg_four, cfg_stag, cfg_half, cfg_bist} <= {four, stag, half, bist};
      slot       <= last ? 2'd0 : slot + 2'd1;
      hold[slot] <= sample_in;
      phase      <= phase ^ (last & gate);
      drq        <= half ? (drq ^ (last & gate)) : last;
      for (int k = 0; k < 4; k++) begin
        stb[k] <= stag && (slot == 2'(k)) && (k < 2 || four);
        if ((stag ? (slot == 2'(k)) : last) && (k < 2 || four))
          word[k] <= bist ? {1'b0, pat(k, phase)}
                          : ((slot == 2'(k)) ? sample_in : hold[k]);
      end
    end
  end

  always_comb
    for (int k = 0; k < 4; k++)
      vis[k] = live ? {(cfg_stag ? stb[k] : word[k][DW]), word[k][DW-1:0]} : '0;

  assign port_a     = vis[0];
  assign port_b     = vis[1];
  assign port_c     = vis[2];
  assign port_d     = vis[3];
  assign data_ready = live & drq;

  assert_quiet_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (boot < LIVE_AT) |-> (data_ready == 1'b0 && port_a == '0 && port_b == '0 && port_c == '0 && port_d == '0));

  assert_two_port_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !cfg_four) |-> (port_c == '0 && port_d == '0));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && cfg_stag) |-> ($countones({port_a[DW], port_b[DW], port_c[DW], port_d[DW]}) == 1));

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !cfg_half && data_ready) |=> !data_ready);

  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !first |=> $stable({cfg_four, cfg_stag, cfg_half, cfg_bist}));

  assert_selftest_c_inverted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && cfg_bist && !cfg_stag) |-> (port_a[DW-1:0] == ~port_c[DW-1:0] && port_a == port_d));
endmodule

// File: tb/word_demux_bench.sv
`timescale 1ns/1ps
module word_demux_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] sample_in = '0;
  logic        ratio_sel = 1'b0, stagger_sel = 1'b0, dr_half_sel = 1'b0, selftest_sel = 1'b0;
  logic [10:0] port_a, port_b, port_c, port_d;
  logic        data_ready;

  always #4 clk = ~clk;

  word_demux u_word_demux (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in),
    .ratio_sel(ratio_sel), .stagger_sel(stagger_sel),
    .dr_half_sel(dr_half_sel), .selftest_sel(selftest_sel),
    .port_a(port_a), .port_b(port_b), .port_c(port_c), .port_d(port_d),
    .data_ready(data_ready)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [10:0] stim [0:255];
  bit m_stag, m_half, m_bist;
  int nports;

  function automatic logic [9:0] patv(int k, int ph);
    logic [9:0] b;
    for (int i = 0; i < 10; i++) b[i] = i[0];
    if (k == 2) b = ~b;
    if (ph != 0) b = ~b;
    return b;
  endfunction

  function automatic logic [10:0] exp_port(int k, int e);
    int le, fe, ph;
    logic s;
    if (e < 8 || k >= nports) return '0;
    if (m_stag) begin
      le = e - ((e - 1 - k) % nports);
      s  = (((e - 1) % nports) == k);
      ph = (le <= 8) ? 0 : (((le - 9) / 4 + 1) % 2);
      return m_bist ? {s, patv(k, ph)} : {s, stim[le][9:0]};
    end
    fe = e - (e % nports);
    ph = (fe <= 8) ? 0 : (((fe - 8) / 4) % 2);
    return m_bist ? {1'b0, patv(k, ph)} : stim[fe - nports + 1 + k];
  endfunction

  function automatic logic exp_dr(int e);
    if (e < 8) return 1'b0;
    if (m_half) return (((e - 8) / nports) % 2) == 0;
    return (e % nports) == 0;
  endfunction

  task automatic chk(string tag, int e, logic [10:0] act, logic [10:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s edge %0d: actual %h expected %h", tag, e, act, exp);
    end
  endtask

  task automatic run_case(bit f, bit s, bit h, bit b, int cycles, bit scramble);
    string tp, td;
    m_stag = s; m_half = h; m_bist = b;
    nports = (f || b) ? 4 : 2;
    @(negedge clk);
    rst_n = 1'b0;
    ratio_sel = f; stagger_sel = s; dr_half_sel = h; selftest_sel = b;
    sample_in = '0;
    @(negedge clk);
    chk("R8 reset port_a", 0, port_a, '0);
    chk("R8 reset port_d", 0, port_d, '0);
    chk("R8 reset data_ready", 0, {10'd0, data_ready}, '0);
    rst_n = 1'b1;
    for (int e = 1; e <= cycles; e++) begin
      stim[e] = 11'($urandom);
      sample_in = stim[e];
      if (scramble && e > 1) begin
        ratio_sel = 1'($urandom); stagger_sel = 1'($urandom);
        dr_half_sel = 1'($urandom); selftest_sel = 1'($urandom);
      end
      @(negedge clk);
      if (e < 8) tp = "R8";
      else if (b) tp = "R7";
      else if (s) tp = (nports == 4) ? "R2/R4" : "R1/R4";
      else tp = (nports == 4) ? "R2/R3" : "R1/R3";
      td = (e < 8) ? "R8" : (h ? "R6" : "R5");
      if (scramble) begin tp = {tp, " R9"}; td = {td, " R9"}; end
      chk({tp, " port_a"}, e, port_a, exp_port(0, e));
      chk({tp, " port_b"}, e, port_b, exp_port(1, e));
      chk({(nports == 2 && e >= 8) ? "R1" : tp, " port_c"}, e, port_c, exp_port(2, e));
      chk({(nports == 2 && e >= 8) ? "R1" : tp, " port_d"}, e, port_d, exp_port(3, e));
      chk({td, " data_ready"}, e, {10'd0, data_ready}, {10'd0, exp_dr(e)});
    end
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk("R8 async port_a", -1, port_a, '0);
    chk("R8 async port_b", -1, port_b, '0);
    chk("R8 async data_ready", -1, {10'd0, data_ready}, '0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    run_case(0, 0, 0, 0, 40, 0);
    run_case(1, 0, 0, 0, 40, 0);
    run_case(0, 1, 1, 0, 40, 0);
    run_case(1, 1, 1, 0, 40, 0);
    run_case(0, 0, 1, 0, 30, 0);
    run_case(1, 1, 0, 0, 30, 0);
    run_case(0, 0, 0, 1, 40, 0);
    run_case(1, 1, 1, 1, 40, 0);
    run_case(0, 1, 0, 0, 60, 1);
    run_case(1, 0, 1, 0, 60, 1);
    run_case(0, 0, 0, 1, 60, 1);
    for (int r = 0; r < 6; r++)
      run_case(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 20 + int'($urandom % 40), 1'($urandom));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule